// File: doc/BRIEF.md
# Asynchronous Serial Port, 10-bit Frame Mode

A full-duplex asynchronous serial port with a CPU-facing register pair. One frame carries a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts 16 ticks of a baud tick input. The transmit and receive sides each take their own tick, so their rates can be chosen independently by an external baud generator.

A CPU write to the data address loads the transmit shifter and starts a frame. A read of the data address returns the last byte that was accepted by the receiver. The receiver oversamples the RX line. It detects a falling edge, takes every bit as the majority of tick samples 7, 8 and 9, and drops a start bit that reads high at mid-bit. A received frame is stored only if two conditions hold: the receive-done flag must be clear, and in multiprocessor mode the stop bit must be 1. The control/status address holds the receive enable, multiprocessor enable and interrupt enable bits, the received stop bit, and the two done flags. Hardware sets the done flags and software clears them. The interrupt output is raised when it is enabled and either done flag is set.

Top module: `async_serial_port`

## Requirements
- R1: After reset tx_o is 1, irq_o is 0, and a read of the control address (addr_i=0) and of the data address (addr_i=1) both return 0.
- R2: A write to addr_i=1 while the transmitter is idle sends one frame on tx_o: one low start bit, the eight data bits LSB first, and one high stop bit, each 16 tx_tick_i ticks long. tx_o idles high.
- R3: The transmit-done flag (control bit 1) is still 0 while data bit 7 is on the line and becomes 1 once the stop bit begins.
- R4: With receive enable (control bit 4) at 1, a frame on rx_i is accepted when the receive-done flag (control bit 0) is 0 and the multiprocessor bit is 0. The byte is then readable at addr_i=1, the stop bit appears in control bit 2, and control bit 0 becomes 1. This holds for a stop bit of 0 as well.
- R5: With receive enable at 0, a frame on rx_i changes neither the data register nor control bit 0.
- R6: A frame that completes while control bit 0 is 1 leaves the data register and control bit 2 unchanged.
- R7: With the multiprocessor bit (control bit 3) at 1, a frame with a stop bit of 0 is not accepted, and a frame with a stop bit of 1 is accepted.
- R8: A low pulse on rx_i that reads high by mid-bit is dropped as a glitch. No frame is stored, and the next valid frame is received correctly.
- R9: Control bits 0 and 1 are cleared only by writing 0 to them. Writing 1 to them has no effect.
- R10: irq_o is 1 exactly when the interrupt enable (control bit 5) is 1 and control bit 0 or bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control/status, 1 data |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| tx_tick_i | input | 1 | Transmit baud tick, 16 per bit |
| rx_tick_i | input | 1 | Receive baud tick, 16 per bit |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Interrupt request |

## Verification
The transmitter is tried with two byte values whose bits alternate in different ways. A swapped bit order or a shifted bit slot therefore shows up as a mismatch, and the done flag is sampled on both sides of the stop-bit boundary. The receiver gets the same frame shape under each gating condition: disabled, flag already set, multiprocessor mode with a stop bit of 0 and of 1, and normal mode with a stop bit of 0. Each case differs from the accepted case by a single condition, so a wrongly ordered or missing load gate is exposed. A short low pulse ahead of a good frame shows whether the start check at mid-bit works. Writes of 1 and of 0 to the flags separate the software clear path from the hardware set path, and the interrupt is observed with its enable both off and on.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  // control/status bit positions
  localparam int unsigned CB_RXD  = 0;
  localparam int unsigned CB_TXD  = 1;
  localparam int unsigned CB_STOP = 2;
  localparam int unsigned CB_MP   = 3;
  localparam int unsigned CB_REN  = 4;
  localparam int unsigned CB_IEN  = 5;

  typedef enum logic {RX_IDLE = 1'b0, RX_BUSY = 1'b1} rx_state_e;
endpackage

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          tick_i,
  output logic          tx_o,
  output logic          done_o
);
  localparam int unsigned FW = DW + 2;
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = $clog2(FW);

  logic          active_q;
  logic [FW-1:0] frame_q;
  logic [CW-1:0] tcnt_q;
  logic [IW-1:0] bidx_q;
  logic          bit_end;

  assign bit_end = active_q && tick_i && (tcnt_q == CW'(OVS-1));
  // pulse as the last data bit ends, i.e. as the stop bit begins
  assign done_o  = bit_end && (bidx_q == IW'(FW-2));
  assign tx_o    = active_q ? frame_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      frame_q  <= '1;
      tcnt_q   <= '0;
      bidx_q   <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      frame_q  <= {1'b1, data_i, 1'b0};
      tcnt_q   <= '0;
      bidx_q   <= '0;
    end else if (active_q && tick_i) begin
      if (bit_end) begin
        tcnt_q <= '0;
        if (bidx_q == IW'(FW-1)) begin
          active_q <= 1'b0;
        end else begin
          bidx_q  <= bidx_q + 1'b1;
          frame_q <= {1'b1, frame_q[FW-1:1]};
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !active_q) |=> !tx_o);
  assert_stop_follows_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> tx_o);
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          rx_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          stop_o
);
  localparam int unsigned CW     = $clog2(OVS);
  localparam int unsigned IW     = $clog2(DW + 2);
  localparam int unsigned MID_LO = OVS/2 - 1;
  localparam int unsigned MID_HI = OVS/2 + 1;

  rx_state_e     st_q;
  logic [1:0]    sync_q;
  logic          prev_q;
  logic [CW-1:0] tcnt_q;
  logic [IW-1:0] bidx_q;
  logic [1:0]    votes_q;
  logic [DW-1:0] shift_q;
  logic          valid_q, stop_q;
  logic          line, vote;

  assign line    = sync_q[1];
  assign vote    = (votes_q[1] & votes_q[0]) | (votes_q[1] & line) | (votes_q[0] & line);
  assign valid_o = valid_q;
  assign data_o  = shift_q;
  assign stop_o  = stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      st_q    <= RX_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      votes_q <= '0;
      shift_q <= '0;
      valid_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rx_i};
      valid_q <= 1'b0;
      if (!en_i) begin
        st_q   <= RX_IDLE;
        prev_q <= 1'b1;
      end else if (tick_i) begin
        prev_q <= line;
        if (st_q == RX_IDLE) begin
          if (prev_q && !line) begin
            st_q   <= RX_BUSY;
            tcnt_q <= '0;
            bidx_q <= '0;
          end
        end else begin
          if (tcnt_q == CW'(OVS-1)) begin
            tcnt_q <= '0;
            bidx_q <= bidx_q + 1'b1;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
          if (tcnt_q >= CW'(MID_LO) && tcnt_q < CW'(MID_HI))
            votes_q <= {votes_q[0], line};
          if (tcnt_q == CW'(MID_HI)) begin
            if (bidx_q == '0) begin
              if (vote) st_q <= RX_IDLE;  // glitch, not a start bit
            end else if (bidx_q == IW'(DW+1)) begin
              valid_q <= 1'b1;
              stop_q  <= vote;
              st_q    <= RX_IDLE;
            end else begin
              shift_q <= {vote, shift_q[DW-1:1]};
            end
          end
        end
      end
    end
  end

  assert_idle_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == RX_IDLE) && !valid_o);
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tx_tick_i,
  input  logic          rx_tick_i,
  input  logic          rx_i,
  output logic          tx_o,
  output logic          irq_o
);
  logic          wr_data, wr_ctrl;
  logic          tx_done, rx_valid, rx_stop, accept;
  logic [DW-1:0] rx_data;
  logic [DW-1:0] rbuf_q;
  logic          rxd_q, txd_q, stop_q, mp_q, ren_q, ien_q;
  logic [DW-1:0] ctrl_rd;

  assign wr_data = wr_en_i && (addr_i == ADDR_DATA);
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  // load gate: buffer free, and in multiprocessor mode a high stop bit
  assign accept  = rx_valid && !rxd_q && (!mp_q || rx_stop);

  asp_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wr_data),
    .data_i (wdata_i),
    .tick_i (tx_tick_i),
    .tx_o   (tx_o),
    .done_o (tx_done)
  );

  asp_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ren_q),
    .tick_i (rx_tick_i),
    .rx_i   (rx_i),
    .valid_o(rx_valid),
    .data_o (rx_data),
    .stop_o (rx_stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q <= '0;
      rxd_q  <= 1'b0;
      txd_q  <= 1'b0;
      stop_q <= 1'b0;
      mp_q   <= 1'b0;
      ren_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mp_q  <= wdata_i[CB_MP];
        ren_q <= wdata_i[CB_REN];
        ien_q <= wdata_i[CB_IEN];
        rxd_q <= rxd_q & wdata_i[CB_RXD];
        txd_q <= txd_q & wdata_i[CB_TXD];
      end
      // hardware set wins over a same-cycle software clear
      if (tx_done) txd_q <= 1'b1;
      if (accept) begin
        rbuf_q <= rx_data;
        stop_q <= rx_stop;
        rxd_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_RXD]  = rxd_q;
    ctrl_rd[CB_TXD]  = txd_q;
    ctrl_rd[CB_STOP] = stop_q;
    ctrl_rd[CB_MP]   = mp_q;
    ctrl_rd[CB_REN]  = ren_q;
    ctrl_rd[CB_IEN]  = ien_q;
  end

  assign rdata_o = (addr_i == ADDR_DATA) ? rbuf_q : ctrl_rd;
  assign irq_o   = ien_q && (rxd_q || txd_q);

  assert_full_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && rxd_q) |=> $stable(rbuf_q) && $stable(stop_q));
  assert_mp_stop_low_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && mp_q && !rx_stop) |=> $stable(rbuf_q) && $stable(stop_q));
  assert_txd_on_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd_q) |-> tx_o);
  assert_flag_clear_by_sw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rxd_q) || $fell(txd_q)) |-> $past(wr_en_i && (addr_i == ADDR_CTRL)));
endmodule

// File: tb/async_serial_port_tb_top.sv
module async_serial_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_tick = 1'b0, rx_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       tx_line, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  localparam int BIT_CLKS = 64;  // 16 ticks x 4 clocks

  always #5 clk = ~clk;

  async_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_tick_i(tx_tick), .rx_tick_i(rx_tick),
    .rx_i(rx_line), .tx_o(tx_line), .irq_o(irq)
  );

  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n = n + 1;
      tx_tick = (n % 4 == 0);
      rx_tick = (n % 4 == 2);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic send_frame(logic [7:0] b, logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_line = f[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 tx idle", tx_line, 1);
    check("R1 irq", irq, 0);
    reg_rd(1'b0, d); check("R1 ctrl", d, 8'h00);
    reg_rd(1'b1, d); check("R1 data", d, 8'h00);
  endtask

  task automatic t_tx(logic [7:0] b);
    logic [7:0] d;
    int guard = 0;
    reg_wr(1'b1, b);
    while (tx_line && guard < 100) begin @(negedge clk); guard++; end
    repeat (BIT_CLKS/2) @(negedge clk);
    check("R2 start bit", tx_line, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CLKS) @(negedge clk);
      check("R2 data bit", tx_line, b[i]);
    end
    reg_rd(1'b0, d); check("R3 txd low during d7", d[1], 0);
    repeat (BIT_CLKS - 1) @(negedge clk);
    check("R2 stop bit", tx_line, 1);
    reg_rd(1'b0, d); check("R3 txd set in stop", d[1], 1);
    check("R10 irq off when disabled", irq, 0);
    repeat (BIT_CLKS) @(negedge clk);
    check("R2 idle high", tx_line, 1);
    reg_wr(1'b0, 8'h00);
    reg_rd(1'b0, d); check("R9 txd cleared by 0", d[1], 0);
  endtask

  task automatic t_rx_basic;
    logic [7:0] d;
    reg_wr(1'b0, 8'h10);
    send_frame(8'h5A, 1'b1);
    reg_rd(1'b1, d); check("R4 data", d, 8'h5A);
    reg_rd(1'b0, d); check("R4 rxd", d[0], 1); check("R4 stop", d[2], 1);
    check("R10 irq off", irq, 0);
    reg_wr(1'b0, 8'h31);
    check("R10 irq on", irq, 1);
    reg_rd(1'b0, d); check("R9 rxd kept by 1", d[0], 1);
    reg_wr(1'b0, 8'h30);
    check("R10 irq after clear", irq, 0);
    reg_rd(1'b0, d); check("R9 rxd cleared", d[0], 0);
    reg_wr(1'b0, 8'h33);
    reg_rd(1'b0, d); check("R9 write 1 no set", d[1:0], 0);
    reg_wr(1'b0, 8'h10);
  endtask

  task automatic t_rx_full;
    logic [7:0] d;
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b0);
    reg_rd(1'b1, d); check("R6 data kept", d, 8'h11);
    reg_rd(1'b0, d); check("R6 stop kept", d[2], 1); check("R6 rxd", d[0], 1);
    reg_wr(1'b0, 8'h10);
  endtask

  task automatic t_rx_off;
    logic [7:0] d;
    reg_wr(1'b0, 8'h00);
    send_frame(8'h77, 1'b1);
    reg_rd(1'b0, d); check("R5 rxd stays 0", d[0], 0);
    reg_rd(1'b1, d); check("R5 data kept", d, 8'h11);
    reg_wr(1'b0, 8'h10);
  endtask

  task automatic t_mp;
    logic [7:0] d;
    reg_wr(1'b0, 8'h18);
    send_frame(8'h44, 1'b0);
    reg_rd(1'b0, d); check("R7 stop0 blocked", d[0], 0);
    reg_rd(1'b1, d); check("R7 data kept", d, 8'h11);
    send_frame(8'h99, 1'b1);
    reg_rd(1'b1, d); check("R7 stop1 loaded", d, 8'h99);
    reg_rd(1'b0, d); check("R7 rxd", d[0], 1);
    reg_wr(1'b0, 8'h10);
    send_frame(8'h66, 1'b0);
    reg_rd(1'b1, d); check("R4 stop0 normal mode", d, 8'h66);
    reg_rd(1'b0, d); check("R4 ninth 0", d[2], 0); check("R4 rxd", d[0], 1);
    reg_wr(1'b0, 8'h10);
  endtask

  task automatic t_glitch;
    logic [7:0] d;
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    reg_rd(1'b0, d); check("R8 glitch dropped", d[0], 0);
    send_frame(8'hC3, 1'b1);
    reg_rd(1'b1, d); check("R8 next frame", d, 8'hC3);
    reg_rd(1'b0, d); check("R8 rxd", d[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx(8'hA5);
    t_tx(8'h3C);
    t_rx_basic();
    t_rx_full();
    t_rx_off();
    t_mp();
    t_glitch();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule